// File: doc/BRIEF.md
# Root Port Legacy Interrupt Queue

This block gathers legacy INTx assert and deassert events seen by a PCIe root port and holds them in a circular queue until software consumes them. Each event carries a lane number (one of four) and a level. Software sees the oldest queued event through two head-entry registers. Writing either of those registers retires that event. A pending-cause register and a mask register combine into a single level-sensitive interrupt output. The cause register uses write-1-to-clear semantics, and its INTx bit cannot be cleared while the queue still holds events.

A root-port status/control register holds a read/write bridge-enable bit, a queue-occupied flag and a sticky overflow flag. An event that arrives when the queue is full is dropped and sets the overflow flag. A PHY status register reports the link-up input. All access uses a simple 32-bit register port with registered read data.

Top module: `rp_intx_queue`

## Requirements
- R1: After reset, the cause (0x138), mask (0x13C), status/control (0x148) and both head-entry registers (0x158, 0x15C) read zero, and `irq` is low.
- R2: Each accepted event is queued in arrival order. While the queue holds events, the head word at 0x158 reads bit 31 = 1, bit 30 = 0, bit 29 = event level, bits 28:27 = lane and bits 26:0 = 0. The word at 0x15C reads zero.
- R3: An accepted event sets cause bit 16. Writing the cause register clears each bit written as 1. However, bit 16 stays 1 as long as the queue holds any event.
- R4: The mask register (0x13C) is read/write on all 32 bits. On the same clock edge that updates cause or mask, `irq` is registered as the OR of (cause AND mask).
- R5: The queue has 16 slots, of which 15 are usable. An event that arrives while 15 are held, with no pop in the same cycle, is dropped. The drop sets status/control bit 19, which is cleared only by reset.
- R6: A write of any value to 0x158 or 0x15C removes the head event. Such a write to an empty queue changes nothing.
- R7: With the queue empty, both head-entry registers read zero.
- R8: If an event arrives in the same cycle as a pop, the pop is applied first. A full queue therefore accepts that event.
- R9: Status/control bit 0 is a read/write bridge enable. Bit 18 reads 1 exactly when the queue holds events. All other bits of a write to this register are ignored.
- R10: PHY status (0x144) bit 11 reads the `link_up` input. All other bits of that register read 0.
- R11: Read data appears on `reg_rdata` one cycle after a `reg_rd` request. Unmapped offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_valid | input | 1 | INTx event strobe |
| evt_lane | input | 2 | Lane of the event |
| evt_level | input | 1 | 1 = assert, 0 = deassert |
| link_up | input | 1 | Link status from the PHY |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt output |

## Verification
The queue is exercised with single events on different lanes and levels, which separates the lane field from the level field. It is filled to exactly 15 entries and then sent one extra event, which shows the drop and the sticky flag and confirms the accepted entries are unharmed. A push coinciding with a pop on a full queue distinguishes pop-first ordering from push-first ordering. Cause clears are issued both with entries queued and with the queue empty, which shows whether the INTx bit is forced back on.

// File: rtl/rpq_pkg.sv
package rpq_pkg;
  localparam int OFF_CAUSE  = 'h138;
  localparam int OFF_MASK   = 'h13C;
  localparam int OFF_PHY    = 'h144;
  localparam int OFF_STAT   = 'h148;
  localparam int OFF_HEAD1  = 'h158;
  localparam int OFF_HEAD2  = 'h15C;

  localparam int CAUSE_INTX_BIT = 16;
  localparam int PHY_LINK_BIT   = 11;
  localparam int STAT_BRG_BIT   = 0;
  localparam int STAT_OCC_BIT   = 18;
  localparam int STAT_OVF_BIT   = 19;
  localparam int HEAD_LANE_LSB  = 27;
  localparam int HEAD_LVL_BIT   = 29;
  localparam int HEAD_VLD_BIT   = 31;
endpackage

// File: rtl/rpq_ring.sv
module rpq_ring #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              pop_i,
  output logic              push_ok_o,
  output logic              drop_o,
  output logic [DATA_W-1:0] head_o,
  output logic              not_empty_o,
  output logic              not_empty_nxt_o
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr, wr_nxt, rd_nxt;
  logic              pop_ok, full_eff, full_now;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign not_empty_o     = (wr_ptr != rd_ptr);
  assign pop_ok          = pop_i & not_empty_o;
  assign rd_nxt          = pop_ok ? bump(rd_ptr) : rd_ptr;
  assign full_eff        = (bump(wr_ptr) == rd_nxt);
  assign full_now        = (bump(wr_ptr) == rd_ptr);
  assign push_ok_o       = push_i & ~full_eff;
  assign drop_o          = push_i & full_eff;
  assign wr_nxt          = push_ok_o ? bump(wr_ptr) : wr_ptr;
  assign not_empty_nxt_o = (wr_nxt != rd_nxt);
  assign head_o          = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      wr_ptr <= wr_nxt;
      rd_ptr <= rd_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok_o) mem[wr_ptr] <= push_data_i;
  end

  // R5: a dropped event leaves the write side untouched
  a_r5_drop_holds_wr: assert property (@(posedge clk) disable iff (rst)
    push_i && full_now && !pop_i |=> $stable(wr_ptr));
  // R6: popping an empty queue does not move the read side
  a_r6_empty_pop_ignored: assert property (@(posedge clk) disable iff (rst)
    pop_i && !not_empty_o && !push_i |=> $stable(rd_ptr));
  // R8: pop before push keeps a full queue full
  a_r8_pop_first: assert property (@(posedge clk) disable iff (rst)
    push_i && pop_i && full_now |=> (bump(wr_ptr) == rd_ptr));
endmodule

// File: rtl/rpq_cause.sv
module rpq_cause #(
  parameter int REG_W    = 32,
  parameter int INTX_BIT = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_ok_i,
  input  logic             clr_wr_i,
  input  logic             clr_intx_i,
  input  logic             mask_wr_i,
  input  logic [REG_W-1:0] mask_data_i,
  input  logic             not_empty_i,
  input  logic             not_empty_nxt_i,
  output logic             intx_o,
  output logic [REG_W-1:0] mask_o,
  output logic             irq_o
);
  logic             intx_d;
  logic [REG_W-1:0] mask_d;

  always_comb begin
    intx_d = (intx_o | push_ok_i) & ~(clr_wr_i & clr_intx_i);
    if (not_empty_nxt_i) intx_d = 1'b1;
    mask_d = mask_wr_i ? mask_data_i : mask_o;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      intx_o <= 1'b0;
      mask_o <= '0;
      irq_o  <= 1'b0;
    end else begin
      intx_o <= intx_d;
      mask_o <= mask_d;
      irq_o  <= intx_d & mask_d[INTX_BIT];
    end
  end

  // R3: INTx cause is held while events remain queued
  a_r3_intx_while_queued: assert property (@(posedge clk) disable iff (rst)
    not_empty_i |-> intx_o);
  // R4: the output can only rise with the INTx bit unmasked
  a_r4_irq_needs_mask: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> (mask_o[INTX_BIT] && intx_o));
endmodule

// File: rtl/rp_intx_queue.sv
module rp_intx_queue #(
  parameter int DEPTH  = 16,
  parameter int LANES  = 4,
  parameter int ADDR_W = 12,
  parameter int REG_W  = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     evt_valid,
  input  logic [$clog2(LANES)-1:0] evt_lane,
  input  logic                     evt_level,
  input  logic                     link_up,
  input  logic                     reg_wr,
  input  logic                     reg_rd,
  input  logic [ADDR_W-1:0]        reg_addr,
  input  logic [REG_W-1:0]         reg_wdata,
  output logic [REG_W-1:0]         reg_rdata,
  output logic                     irq
);
  import rpq_pkg::*;

  localparam int LANE_W = $clog2(LANES);
  localparam int ENT_W  = LANE_W + 1;

  logic             sel_cause, sel_mask, sel_phy, sel_stat, sel_head1, sel_head2;
  logic             pop, push_ok, drop, not_empty, not_empty_nxt, intx;
  logic [ENT_W-1:0] head;
  logic [REG_W-1:0] mask, rd_mux, head_word, stat_word, phy_word, cause_word;
  logic             bridge_q, ovf_q;

  assign sel_cause = (reg_addr == ADDR_W'(OFF_CAUSE));
  assign sel_mask  = (reg_addr == ADDR_W'(OFF_MASK));
  assign sel_phy   = (reg_addr == ADDR_W'(OFF_PHY));
  assign sel_stat  = (reg_addr == ADDR_W'(OFF_STAT));
  assign sel_head1 = (reg_addr == ADDR_W'(OFF_HEAD1));
  assign sel_head2 = (reg_addr == ADDR_W'(OFF_HEAD2));
  assign pop       = reg_wr & (sel_head1 | sel_head2);

  rpq_ring #(.DEPTH(DEPTH), .DATA_W(ENT_W)) u_ring (
    .clk(clk), .rst(rst),
    .push_i(evt_valid), .push_data_i({evt_level, evt_lane}),
    .pop_i(pop), .push_ok_o(push_ok), .drop_o(drop),
    .head_o(head), .not_empty_o(not_empty), .not_empty_nxt_o(not_empty_nxt)
  );

  rpq_cause #(.REG_W(REG_W), .INTX_BIT(CAUSE_INTX_BIT)) u_cause (
    .clk(clk), .rst(rst),
    .push_ok_i(push_ok),
    .clr_wr_i(reg_wr & sel_cause), .clr_intx_i(reg_wdata[CAUSE_INTX_BIT]),
    .mask_wr_i(reg_wr & sel_mask), .mask_data_i(reg_wdata),
    .not_empty_i(not_empty), .not_empty_nxt_i(not_empty_nxt),
    .intx_o(intx), .mask_o(mask), .irq_o(irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bridge_q <= 1'b0;
      ovf_q    <= 1'b0;
    end else begin
      if (reg_wr && sel_stat) bridge_q <= reg_wdata[STAT_BRG_BIT];
      if (drop) ovf_q <= 1'b1;
    end
  end

  always_comb begin
    head_word = '0;
    if (not_empty) begin
      head_word[HEAD_VLD_BIT] = 1'b1;
      head_word[HEAD_LVL_BIT] = head[ENT_W-1];
      head_word[HEAD_LANE_LSB +: LANE_W] = head[LANE_W-1:0];
    end
    stat_word = '0;
    stat_word[STAT_BRG_BIT] = bridge_q;
    stat_word[STAT_OCC_BIT] = not_empty;
    stat_word[STAT_OVF_BIT] = ovf_q;
    phy_word = '0;
    phy_word[PHY_LINK_BIT] = link_up;
    cause_word = '0;
    cause_word[CAUSE_INTX_BIT] = intx;
    rd_mux = '0;
    if (sel_cause) rd_mux = cause_word;
    if (sel_mask)  rd_mux = mask;
    if (sel_phy)   rd_mux = phy_word;
    if (sel_stat)  rd_mux = stat_word;
    if (sel_head1) rd_mux = head_word;
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end

  // R5: overflow flag is sticky until reset
  a_r5_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    ovf_q |=> ovf_q);
  // R9: queue-occupied status and cause INTx bit agree when entries exist
  a_r9_occ_implies_intx: assert property (@(posedge clk) disable iff (rst)
    stat_word[STAT_OCC_BIT] |-> intx);
endmodule

// File: tb/tb_rp_intx_queue.sv
module tb_rp_intx_queue;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        evt_valid = 1'b0;
  logic [1:0]  evt_lane = '0;
  logic        evt_level = 1'b0;
  logic        link_up = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [31:0] exp_q[$];

  always #4 clk = ~clk;

  rp_intx_queue dut (
    .clk(clk), .rst(rst), .evt_valid(evt_valid), .evt_lane(evt_lane),
    .evt_level(evt_level), .link_up(link_up), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  function automatic logic [31:0] word(input logic [1:0] lane, input logic lvl);
    return 32'h8000_0000 | (32'(lvl) << 29) | (32'(lane) << 27);
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  // driver: pushes an event and the expected head word into the scoreboard
  task automatic push_evt(input logic [1:0] lane, input logic lvl);
    evt_valid = 1'b1; evt_lane = lane; evt_level = lvl;
    @(negedge clk);
    evt_valid = 1'b0;
    if (exp_q.size() < 15) exp_q.push_back(word(lane, lvl));
  endtask

  // monitor: reads the head, compares with the scoreboard, then pops
  task automatic pop_check(input string tag, input logic [11:0] pop_addr);
    logic [31:0] d;
    logic [31:0] e;
    rd(12'h158, d);
    e = exp_q.pop_front();
    check(tag, d, e);
    wr(pop_addr, 32'h1234_5678);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    rd(12'h138, d); check("R1 cause", d, 0);
    rd(12'h13C, d); check("R1 mask", d, 0);
    rd(12'h148, d); check("R1 status", d, 0);
    rd(12'h158, d); check("R1 R7 head1", d, 0);
    rd(12'h15C, d); check("R1 R7 head2", d, 0);
    check("R1 irq", {31'b0, irq}, 0);

    // R10 link status, R11 unmapped
    link_up = 1'b1;
    rd(12'h144, d); check("R10 link up", d, 32'h0000_0800);
    link_up = 1'b0;
    rd(12'h144, d); check("R10 link down", d, 0);
    rd(12'h100, d); check("R11 unmapped", d, 0);

    // R4 mask
    wr(12'h13C, 32'hA5A5_FFFF);
    rd(12'h13C, d); check("R4 mask rw", d, 32'hA5A5_FFFF);
    check("R4 irq idle", {31'b0, irq}, 0);

    // R2 R3 R4 first event
    push_evt(2'd2, 1'b1);
    check("R4 irq after push", {31'b0, irq}, 1);
    rd(12'h138, d); check("R3 cause set", d, 32'h0001_0000);
    rd(12'h148, d); check("R9 occupied", d, 32'h0004_0000);
    rd(12'h15C, d); check("R2 head2 zero", d, 0);
    wr(12'h138, 32'hFFFF_FFFF);
    rd(12'h138, d); check("R3 clear blocked", d, 32'h0001_0000);

    // R6 pop through either register
    push_evt(2'd1, 1'b0);
    pop_check("R2 R6 first", 12'h15C);
    pop_check("R2 R6 second", 12'h158);
    rd(12'h158, d); check("R7 empty head1", d, 0);
    rd(12'h138, d); check("R3 held after drain", d, 32'h0001_0000);
    wr(12'h138, 32'h0001_0000);
    rd(12'h138, d); check("R3 cleared", d, 0);
    check("R4 irq cleared", {31'b0, irq}, 0);

    // R6 pop on empty changes nothing
    wr(12'h158, 32'hFFFF_FFFF);
    rd(12'h148, d); check("R6 empty pop status", d, 0);
    push_evt(2'd3, 1'b0);
    rd(12'h158, d); check("R6 head after empty pop", d, word(2'd3, 1'b0));

    // R4 masking
    wr(12'h13C, 32'h0);
    check("R4 masked irq", {31'b0, irq}, 0);
    wr(12'h13C, 32'h0001_0000);
    check("R4 unmasked irq", {31'b0, irq}, 1);

    // R9 bridge enable, other bits ignored
    wr(12'h148, 32'hFFFF_FFFF);
    rd(12'h148, d); check("R9 bridge set", d, 32'h0004_0001);
    wr(12'h148, 32'hFFFF_FFFE);
    rd(12'h148, d); check("R9 bridge clear", d, 32'h0004_0000);

    // R5 fill to 15 then overflow
    for (int i = 0; i < 14; i++) push_evt(2'(i), 1'(i >> 2));
    rd(12'h148, d); check("R5 full no ovf", d, 32'h0004_0000);
    push_evt(2'd3, 1'b1);
    rd(12'h148, d); check("R5 ovf set", d, 32'h000C_0000);
    for (int i = 0; i < 15; i++) pop_check("R5 drain order", (i % 2 == 0) ? 12'h158 : 12'h15C);
    rd(12'h158, d); check("R7 empty after drain", d, 0);
    rd(12'h148, d); check("R5 ovf sticky", d, 32'h0008_0000);

    // R8 push with pop on a full queue
    for (int i = 0; i < 15; i++) push_evt(2'(3 - (i % 4)), 1'(i % 2));
    evt_valid = 1'b1; evt_lane = 2'd2; evt_level = 1'b0;
    reg_wr = 1'b1; reg_addr = 12'h158; reg_wdata = 32'h0;
    @(negedge clk);
    evt_valid = 1'b0; reg_wr = 1'b0;
    void'(exp_q.pop_front());
    exp_q.push_back(word(2'd2, 1'b0));
    for (int i = 0; i < 15; i++) pop_check("R8 order after push-pop", 12'h15C);
    rd(12'h148, d); check("R8 empty status", d, 32'h0008_0000);

    // R5 reset clears overflow
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    rd(12'h148, d); check("R5 R1 ovf reset", d, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule